// File: doc/BRIEF.md
# Two-Plane Command Legality Monitor

This block is a passive checker for the device side of a NAND flash bus. It watches the command, address and data cycles that a bus decoder has already separated, together with the ready/busy level, and follows two-plane program and two-plane erase sequences through to the end. It never drives the bus, models no array contents and checks no timing. It checks only the order of cycles and whether the two row addresses form a legal plane pair.

A two-plane program has two phases. The first is command 80h, five address bytes, data bytes and command 11h. Status reads (70h) may follow. The second phase is 81h, five address bytes, data bytes and the confirm 10h. A two-plane erase is one or two groups, each made of 60h and three address bytes, followed by the confirm D0h. When a sequence ends legally, the block pulses a done flag for that operation. When a rule is broken, it pulses an error flag with a code that names the rule. After any error, or after a reset command, the block drops the partial sequence and waits for a new one.

In each five-byte program address, the last three bytes hold the row. In an erase address, all three bytes hold the row. Row bit n is bit n mod 8 of row byte n div 8. Row bits 0 to 5 select the page, row bit 6 selects the plane inside a pair, row bits 7 to 17 select the block, and row bit 18 selects the plane pair.

Top module: `twoPlaneMonitor`

## Requirements
- R1: While reset is held and in the first cycle after it, errValid, progDone and eraseDone are 0 and errCode is 0.
- R2: The sequence 80h, five addresses, data, 11h, any number of 70h, 81h, five addresses, data, 10h produces a progDone pulse with no error, provided the second row passes the checks of R4 to R6. A 70h is also accepted while devReady is low.
- R3: After 11h and before 81h, any command other than 70h or FFh gives error code 1, and the monitor returns to idle.
- R4: The plane bit (bit 6 of the first row byte) must be 0 in the first row and 1 in the second row. Otherwise, at the last address byte of the second row, the monitor reports code 2. Code 2 takes priority over codes 4, 6 and 3, in that order.
- R5: The pair bit (bit 2 of the third row byte) must be the same in both rows. Otherwise the monitor reports code 4.
- R6: All other row bits 0 to 18 must be the same in both rows. Otherwise the monitor reports code 3.
- R7: The sequence 60h, three addresses, optionally 60h and three more addresses, then D0h produces an eraseDone pulse with no error.
- R8: In a two-group erase, page bits 0 to 5 must be zero in both rows. Otherwise the monitor reports code 6.
- R9: A third 60h inside one erase sequence gives code 7.
- R10: If a command or data byte arrives before all address bytes are in (five for program, three for erase), or an address byte arrives after them, the monitor reports code 5.
- R11: A command other than 70h or FFh that arrives while devReady is low gives code 8, whatever the state.
- R12: FFh ends any partial sequence without an error. Cycles that belonged to the dropped sequence then produce neither done nor error.
- R13: Inside a sequence, a command that is not the expected next command, 70h or FFh gives code 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | busIn holds a command byte this cycle |
| addrValid | input | 1 | busIn holds an address byte this cycle |
| dataValid | input | 1 | busIn holds a data byte this cycle |
| busIn | input | 8 | Bus byte |
| devReady | input | 1 | Ready/busy level, 1 when ready |
| errValid | output | 1 | One-cycle pulse when a rule is broken |
| errCode | output | 4 | Code of the broken rule while errValid is 1, else 0 |
| progDone | output | 1 | One-cycle pulse when a two-plane program completes legally |
| eraseDone | output | 1 | One-cycle pulse when an erase completes legally |

## Verification
Every result is registered once. It appears at the clock edge that samples the strobe causing it and lasts exactly one cycle. For the row checks, that strobe is the last address byte of the second row. For the done flags and the command errors, it is the command itself. The bench drives one strobe per cycle on the falling edge and reads the outputs on the next falling edge, inside the single cycle in which the pulse is valid. A separate sampler placed two nanoseconds after each rising edge counts every error pulse, so a legal sequence also proves that no error was raised at any step along the way.

// File: rtl/tpMonPkg.sv
package tpMonPkg;
  localparam int BUS_W = 8;

  localparam logic [BUS_W-1:0] CMD_PROG_SETUP  = 8'h80;
  localparam logic [BUS_W-1:0] CMD_PROG_HOLD   = 8'h11;
  localparam logic [BUS_W-1:0] CMD_PROG_NEXT   = 8'h81;
  localparam logic [BUS_W-1:0] CMD_PROG_GO     = 8'h10;
  localparam logic [BUS_W-1:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [BUS_W-1:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [BUS_W-1:0] CMD_STATUS      = 8'h70;
  localparam logic [BUS_W-1:0] CMD_RESET       = 8'hFF;

  typedef enum logic [3:0] {
    E_NONE        = 4'd0,
    E_INTERLEAVE  = 4'd1,
    E_PLANE       = 4'd2,
    E_ROW         = 4'd3,
    E_PAIR        = 4'd4,
    E_ADDR_CNT    = 4'd5,
    E_PAGE        = 4'd6,
    E_EXTRA_GROUP = 4'd7,
    E_BUSY        = 4'd8,
    E_UNEXPECTED  = 4'd9
  } errCodeT;

  typedef struct packed {
    logic clrCnt;
    logic shift;
    logic saveFirst;
  } addrStbT;
endpackage

// File: rtl/twoPlaneAddrPath.sv
module twoPlaneAddrPath
  import tpMonPkg::*;
#(
  parameter int PROG_CYCLES = 5,
  parameter int ROW_BYTES   = 3,
  parameter int PLANE_BIT   = 6,
  parameter int PAIR_BIT    = 18,
  parameter int PAGE_BITS   = 6,
  parameter int ROW_BITS    = 19,
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1),
  localparam int ROW_W      = ROW_BYTES * BUS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  addrStbT          stb,
  input  logic [BUS_W-1:0] busIn,
  output logic [CNT_W-1:0] addrCnt,
  output logic             planeBad,
  output logic             pairBad,
  output logic             pageBad,
  output logic             rowBad
);
  localparam logic [ROW_W-1:0] SPAN     = {ROW_W{1'b1}} >> (ROW_W - ROW_BITS);
  localparam logic [ROW_W-1:0] ROW_MASK = SPAN & ~(ROW_W'(1) << PLANE_BIT)
                                               & ~(ROW_W'(1) << PAIR_BIT);

  logic [ROW_W-1:0] curRow, firstRow, nextRow;

  assign nextRow = {busIn, curRow[ROW_W-1:BUS_W]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt  <= '0;
      curRow   <= '0;
      firstRow <= '0;
    end else begin
      if (stb.clrCnt) addrCnt <= '0;
      else if (stb.shift) addrCnt <= addrCnt + 1'b1;
      if (stb.shift) curRow <= nextRow;
      if (stb.saveFirst) firstRow <= nextRow;
    end
  end

  assign planeBad = firstRow[PLANE_BIT] | ~nextRow[PLANE_BIT];
  assign pairBad  = firstRow[PAIR_BIT] ^ nextRow[PAIR_BIT];
  assign pageBad  = (|firstRow[PAGE_BITS-1:0]) | (|nextRow[PAGE_BITS-1:0]);
  assign rowBad   = |((firstRow ^ nextRow) & ROW_MASK);

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    addrCnt <= CNT_W'(PROG_CYCLES));
endmodule

// File: rtl/twoPlaneSeqCtrl.sv
module twoPlaneSeqCtrl
  import tpMonPkg::*;
#(
  parameter int PROG_CYCLES  = 5,
  parameter int ERASE_CYCLES = 3,
  localparam int CNT_W       = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             addrValid,
  input  logic             dataValid,
  input  logic [BUS_W-1:0] busIn,
  input  logic             devReady,
  input  logic [CNT_W-1:0] addrCnt,
  input  logic             planeBad,
  input  logic             pairBad,
  input  logic             pageBad,
  input  logic             rowBad,
  output addrStbT          stb,
  output logic             errValid,
  output logic [3:0]       errCode,
  output logic             progDone,
  output logic             eraseDone
);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_P1A, S_P1D, S_GAP, S_P2A, S_P2D, S_E1A, S_E1W, S_E2A, S_E2W
  } stateT;

  stateT   state, nxt;
  errCodeT codeNow;
  logic    progNow, eraseNow, inAddr, inWait, lastAddr;

  assign inAddr   = state inside {S_P1A, S_P2A, S_E1A, S_E2A};
  assign inWait   = state inside {S_P1D, S_P2D, S_E1W, S_E2W};
  assign lastAddr = (state inside {S_E1A, S_E2A}) ? (addrCnt == ERASE_LAST)
                                                  : (addrCnt == PROG_LAST);

  always_comb begin
    nxt      = state;
    stb      = '0;
    codeNow  = E_NONE;
    progNow  = 1'b0;
    eraseNow = 1'b0;
    if (cmdValid) begin
      if (busIn == CMD_RESET) nxt = S_IDLE;
      else if (!devReady && busIn != CMD_STATUS) codeNow = E_BUSY;
      else if (inAddr) codeNow = E_ADDR_CNT;
      else if (busIn != CMD_STATUS) begin
        case (state)
          S_IDLE: begin
            if (busIn == CMD_PROG_SETUP) begin nxt = S_P1A; stb.clrCnt = 1'b1; end
            else if (busIn == CMD_ERASE_SETUP) begin nxt = S_E1A; stb.clrCnt = 1'b1; end
          end
          S_P1D: if (busIn == CMD_PROG_HOLD) nxt = S_GAP; else codeNow = E_UNEXPECTED;
          S_GAP: begin
            if (busIn == CMD_PROG_NEXT) begin nxt = S_P2A; stb.clrCnt = 1'b1; end
            else codeNow = E_INTERLEAVE;
          end
          S_P2D: begin
            if (busIn == CMD_PROG_GO) begin progNow = 1'b1; nxt = S_IDLE; end
            else codeNow = E_UNEXPECTED;
          end
          S_E1W, S_E2W: begin
            if (busIn == CMD_ERASE_GO) begin eraseNow = 1'b1; nxt = S_IDLE; end
            else if (busIn == CMD_ERASE_SETUP && state == S_E1W) begin
              nxt = S_E2A; stb.clrCnt = 1'b1;
            end else if (busIn == CMD_ERASE_SETUP) codeNow = E_EXTRA_GROUP;
            else codeNow = E_UNEXPECTED;
          end
          default: nxt = S_IDLE;
        endcase
      end
    end else if (addrValid) begin
      if (inAddr) begin
        stb.shift = 1'b1;
        if (lastAddr) begin
          case (state)
            S_P1A: begin stb.saveFirst = 1'b1; nxt = S_P1D; end
            S_E1A: begin stb.saveFirst = 1'b1; nxt = S_E1W; end
            S_P2A: begin
              if (planeBad) codeNow = E_PLANE;
              else if (pairBad) codeNow = E_PAIR;
              else if (rowBad) codeNow = E_ROW;
              else nxt = S_P2D;
            end
            default: begin
              if (planeBad) codeNow = E_PLANE;
              else if (pairBad) codeNow = E_PAIR;
              else if (pageBad) codeNow = E_PAGE;
              else if (rowBad) codeNow = E_ROW;
              else nxt = S_E2W;
            end
          endcase
        end
      end else if (inWait) codeNow = E_ADDR_CNT;
    end else if (dataValid && inAddr) begin
      codeNow = E_ADDR_CNT;
    end
    if (codeNow != E_NONE) nxt = S_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      errValid  <= 1'b0;
      errCode   <= '0;
      progDone  <= 1'b0;
      eraseDone <= 1'b0;
    end else begin
      state     <= nxt;
      errValid  <= (codeNow != E_NONE);
      errCode   <= codeNow;
      progDone  <= progNow;
      eraseDone <= eraseNow;
    end
  end

  assert_prog_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    progDone |-> $past(cmdValid && busIn == CMD_PROG_GO));

  assert_erase_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    eraseDone |-> $past(cmdValid && busIn == CMD_ERASE_GO));

  assert_gap_interleave_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_GAP && cmdValid && devReady && busIn != CMD_STATUS &&
     busIn != CMD_RESET && busIn != CMD_PROG_NEXT)
    |=> (errValid && errCode == 4'(E_INTERLEAVE)));

  assert_busy_cmd_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !devReady && busIn != CMD_STATUS && busIn != CMD_RESET)
    |=> (errValid && errCode == 4'(E_BUSY)));

  assert_reset_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && busIn == CMD_RESET) |=> (!errValid && !progDone && !eraseDone));
endmodule

// File: rtl/twoPlaneMonitor.sv
module twoPlaneMonitor
  import tpMonPkg::*;
#(
  parameter int PROG_CYCLES  = 5,
  parameter int ERASE_CYCLES = 3,
  parameter int ROW_BYTES    = 3,
  parameter int PLANE_BIT    = 6,
  parameter int PAIR_BIT     = 18,
  parameter int PAGE_BITS    = 6,
  parameter int ROW_BITS     = 19
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       addrValid,
  input  logic       dataValid,
  input  logic [7:0] busIn,
  input  logic       devReady,
  output logic       errValid,
  output logic [3:0] errCode,
  output logic       progDone,
  output logic       eraseDone
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  addrStbT          stb;
  logic [CNT_W-1:0] addrCnt;
  logic             planeBad, pairBad, pageBad, rowBad;

  twoPlaneAddrPath #(
    .PROG_CYCLES(PROG_CYCLES), .ROW_BYTES(ROW_BYTES), .PLANE_BIT(PLANE_BIT),
    .PAIR_BIT(PAIR_BIT), .PAGE_BITS(PAGE_BITS), .ROW_BITS(ROW_BITS)
  ) i_path (
    .clk(clk), .rstN(rstN), .stb(stb), .busIn(busIn), .addrCnt(addrCnt),
    .planeBad(planeBad), .pairBad(pairBad), .pageBad(pageBad), .rowBad(rowBad)
  );

  twoPlaneSeqCtrl #(
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .addrValid(addrValid),
    .dataValid(dataValid), .busIn(busIn), .devReady(devReady), .addrCnt(addrCnt),
    .planeBad(planeBad), .pairBad(pairBad), .pageBad(pageBad), .rowBad(rowBad),
    .stb(stb), .errValid(errValid), .errCode(errCode), .progDone(progDone),
    .eraseDone(eraseDone)
  );
endmodule

// File: tb/test_twoPlaneMonitor.sv
module test_twoPlaneMonitor;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0, addrValid = 1'b0, dataValid = 1'b0;
  logic [7:0] busIn = '0;
  logic       devReady = 1'b1;
  logic       errValid, progDone, eraseDone;
  logic [3:0] errCode;
  int         nTests = 0, nFail = 0, errSeen = 0;
  bit         finished = 1'b0;

  twoPlaneMonitor i_twoPlaneMonitor (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .addrValid(addrValid),
    .dataValid(dataValid), .busIn(busIn), .devReady(devReady),
    .errValid(errValid), .errCode(errCode), .progDone(progDone), .eraseDone(eraseDone)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    #2;
    if (errValid) errSeen++;
  end

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mkRow(input int page, input int plane,
                                        input int blk, input int pair);
    return {5'b0, 1'(pair), 11'(blk), 1'(plane), 6'(page)};
  endfunction

  task automatic sendCmd(input logic [7:0] b);
    @(negedge clk); cmdValid = 1'b1; busIn = b;
    @(negedge clk); cmdValid = 1'b0;
  endtask

  task automatic sendAddr(input logic [7:0] b);
    @(negedge clk); addrValid = 1'b1; busIn = b;
    @(negedge clk); addrValid = 1'b0;
  endtask

  task automatic sendData(input logic [7:0] b);
    @(negedge clk); dataValid = 1'b1; busIn = b;
    @(negedge clk); dataValid = 1'b0;
  endtask

  task automatic progAddr(input logic [23:0] row);
    sendAddr(8'h12); sendAddr(8'h00);
    sendAddr(row[7:0]); sendAddr(row[15:8]); sendAddr(row[23:16]);
  endtask

  task automatic eraseAddr(input logic [23:0] row);
    sendAddr(row[7:0]); sendAddr(row[15:8]); sendAddr(row[23:16]);
  endtask

  task automatic firstProg(input logic [23:0] row);
    sendCmd(8'h80); progAddr(row); sendData(8'hA5); sendData(8'h5A); sendCmd(8'h11);
  endtask

  task automatic secondProgErr(input logic [23:0] r1, input logic [23:0] r2,
                               input int code, input string req);
    firstProg(r1);
    sendCmd(8'h81); progAddr(r2);
    check(req, errValid, 1);
    check(req, errCode, code);
  endtask

  task automatic t_reset;
    check("R1 errValid", errValid, 0);
    check("R1 errCode", errCode, 0);
    check("R1 progDone", progDone, 0);
    check("R1 eraseDone", eraseDone, 0);
  endtask

  task automatic t_progOk;
    int base = errSeen;
    firstProg(mkRow(5, 0, 100, 1));
    devReady = 1'b0;
    sendCmd(8'h70);
    check("R2 status while busy", errValid, 0);
    devReady = 1'b1;
    sendCmd(8'h81); progAddr(mkRow(5, 1, 100, 1)); sendData(8'h33);
    sendCmd(8'h10);
    check("R2 progDone", progDone, 1);
    @(negedge clk);
    check("R2 progDone one cycle", progDone, 0);
    check("R2 no error", errSeen - base, 0);
  endtask

  task automatic t_interleave;
    firstProg(mkRow(0, 0, 7, 0));
    sendCmd(8'h00);
    check("R3 interleave", errValid, 1);
    check("R3 code", errCode, 1);
    sendCmd(8'h81);
    check("R3 back to idle", errValid, 0);
  endtask

  task automatic t_rowChecks;
    secondProgErr(mkRow(1, 1, 9, 0), mkRow(1, 1, 9, 0), 2, "R4 first plane high");
    secondProgErr(mkRow(1, 0, 9, 0), mkRow(1, 0, 9, 0), 2, "R4 second plane low");
    secondProgErr(mkRow(1, 0, 9, 0), mkRow(1, 0, 9, 1), 2, "R4 priority over pair");
    secondProgErr(mkRow(1, 0, 9, 0), mkRow(1, 1, 9, 1), 4, "R5 pair mismatch");
    secondProgErr(mkRow(1, 0, 9, 1), mkRow(1, 1, 8, 1), 3, "R6 block mismatch");
    secondProgErr(mkRow(1, 0, 9, 1), mkRow(2, 1, 9, 1), 3, "R6 page mismatch");
  endtask

  task automatic t_eraseOk;
    int base = errSeen;
    sendCmd(8'h60); eraseAddr(mkRow(0, 0, 40, 1));
    sendCmd(8'h60); eraseAddr(mkRow(0, 1, 40, 1));
    sendCmd(8'hD0);
    check("R7 two-group eraseDone", eraseDone, 1);
    sendCmd(8'h60); eraseAddr(mkRow(0, 1, 3, 0));
    sendCmd(8'hD0);
    check("R7 single-group eraseDone", eraseDone, 1);
    check("R7 no error", errSeen - base, 0);
  endtask

  task automatic t_erasePage;
    sendCmd(8'h60); eraseAddr(mkRow(4, 0, 40, 0));
    sendCmd(8'h60); eraseAddr(mkRow(4, 1, 40, 0));
    check("R8 page bits", errValid, 1);
    check("R8 code", errCode, 6);
  endtask

  task automatic t_eraseExtra;
    sendCmd(8'h60); eraseAddr(mkRow(0, 0, 2, 0));
    sendCmd(8'h60); eraseAddr(mkRow(0, 1, 2, 0));
    sendCmd(8'h60);
    check("R9 extra group", errValid, 1);
    check("R9 code", errCode, 7);
  endtask

  task automatic t_addrCount;
    sendCmd(8'h80); sendAddr(8'h00); sendAddr(8'h00); sendAddr(8'h00);
    sendData(8'h11);
    check("R10 short program address", errCode, 5);
    sendCmd(8'h60); eraseAddr(mkRow(0, 0, 1, 0)); sendAddr(8'h00);
    check("R10 extra erase address", errCode, 5);
    sendCmd(8'h60); sendAddr(8'h00); sendCmd(8'hD0);
    check("R10 short erase address", errCode, 5);
  endtask

  task automatic t_busy;
    devReady = 1'b0;
    sendCmd(8'h80);
    check("R11 busy command", errValid, 1);
    check("R11 code", errCode, 8);
    sendCmd(8'h70);
    check("R11 status allowed", errValid, 0);
    devReady = 1'b1;
  endtask

  task automatic t_abort;
    int base = errSeen;
    firstProg(mkRow(0, 0, 5, 0));
    sendCmd(8'hFF);
    check("R12 no error on FFh", errValid, 0);
    sendCmd(8'h81); progAddr(mkRow(0, 1, 5, 0)); sendData(8'h01);
    sendCmd(8'h10);
    check("R12 no done after abort", progDone, 0);
    check("R12 no error after abort", errSeen - base, 0);
    sendCmd(8'h60); sendAddr(8'h00); sendCmd(8'hFF);
    check("R12 abort mid-address", errValid, 0);
  endtask

  task automatic t_unexpected;
    sendCmd(8'h80); progAddr(mkRow(0, 0, 1, 0)); sendData(8'h00);
    sendCmd(8'hD0);
    check("R13 unexpected command", errValid, 1);
    check("R13 code", errCode, 9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_progOk();
    t_interleave();
    t_rowChecks();
    t_eraseOk();
    t_erasePage();
    t_eraseExtra();
    t_addrCount();
    t_busy();
    t_abort();
    t_unexpected();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule